// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is the host side of a link to a serial analog-to-digital converter that returns each sample as a 24-bit word: three status bits followed by a 21-bit result. On a start request it pulls the active-low select line down and watches the converter's data line. The converter holds that line high while it is still converting, and pulls it low once a result is ready. Only after it sees that low level does the reader issue exactly 24 serial clock pulses and capture one bit on each rising edge. The first bit received is the most significant.

When the frame is complete, the reader raises select and splits the word into fields. These are the 21-bit result, the sign, overrange and underrange flags taken from the sign/MSB pair, and a frame-error flag set when the dummy bit is not low. The reader then offers the fields on a valid/ready output. If the converter never reports ready within a programmable number of polls, the reader gives up and returns a result marked as timed out.

The serial clock rate is set by a divider parameter. Select stays high for a minimum number of system clocks between reads. An optional ready-interrupt output shows the converter's end-of-conversion level while the reader is polling.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, select is high, the serial clock is low, no result is valid and start_ready_o is high.
- R2: The serial clock idles low, rises only while select is low, and each high and low phase lasts exactly DIV system clocks.
- R3: After select falls, the reader samples the data line once every DIV clocks. It starts clocking only after it samples a low level. With IRQ_EN set, eoc_irq_o is high while the reader is polling and the data line is low.
- R4: Each read that completes without timing out issues exactly 24 rising serial-clock edges. The data line is captured on each rising edge, and the first captured bit is word bit 23.
- R5: res_data_o equals word bits 20..0, and res_sign_o equals word bit 21.
- R6: res_over_o is 1 exactly when word bits 21 and 20 are both 1. res_under_o is 1 exactly when both are 0.
- R7: res_ferr_o is 1 exactly when word bit 22 (the second bit received) is 1.
- R8: If cfg_timeout_i consecutive polls all read high (a value of 0 counts as 1), select rises with no serial clock issued. The result then has res_tout_o=1 and all other fields 0.
- R9: The result handshake is valid/ready. res_valid_o stays high and every result field stays stable until a cycle with res_ready_i high. A start is accepted only in a cycle where both start_valid_i and start_ready_o are high. start_ready_o is low while the reader is busy, while a result is pending, or during the select-high guard time.
- R10: Between two reads, select stays high for at least GAP system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid_i | input | 1 | Read request |
| start_ready_o | output | 1 | Reader can accept a request |
| cfg_timeout_i | input | TW | Maximum number of polls that read high before giving up |
| sdo_i | input | 1 | Converter serial data line |
| csn_o | output | 1 | Active-low select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| eoc_irq_o | output | 1 | Ready indication while polling |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer takes the result |
| res_data_o | output | 21 | Conversion result field |
| res_sign_o | output | 1 | Sign bit |
| res_over_o | output | 1 | Input above positive full scale |
| res_under_o | output | 1 | Input below negative full scale |
| res_ferr_o | output | 1 | Dummy bit was high |
| res_tout_o | output | 1 | Converter never reported ready |

## Verification
The converter model sends frames for all four sign/MSB combinations. This shows that the overrange and underrange decode separates the two in-range cases from the two out-of-range ones. Result patterns with alternating bits and with a single set bit show up shifted, reversed or dropped bits. A frame with a high dummy bit isolates the frame-error path. Varying the ready delay, one run with no ready at all, and a consumer that withholds ready together show how polling differs from the timeout, and check that the held result cannot be overwritten.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int FRAME_W = 24;
  localparam int RES_W   = 21;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_POLL,
    ST_SHIFT,
    ST_DONE
  } rd_state_e;

  typedef struct packed {
    logic [RES_W-1:0] data;
    logic             sign;
    logic             over;
    logic             under;
    logic             ferr;
    logic             tout;
  } rd_result_t;
endpackage

// File: rtl/adcr_tick.sv
module adcr_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!en)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && (cnt_q == LAST);

  // R2
  tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (DIV > 1)) |=> !tick);
endmodule

// File: rtl/adcr_shift.sv
module adcr_shift
  import adcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cap,
  input  logic               din,
  output logic [FRAME_W-1:0] word,
  output logic [CNT_W-1:0]   cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else if (clr) begin
      word <= '0;
      cnt  <= '0;
    end else if (cap) begin
      word <= {word[FRAME_W-2:0], din};
      cnt  <= cnt + 1'b1;
    end
  end

  // R4
  bit_cnt_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> (cnt < CNT_W'(FRAME_W)));
endmodule

// File: rtl/adcr_decode.sv
module adcr_decode
  import adcr_pkg::*;
(
  input  logic [FRAME_W-1:0] word,
  input  logic               tout,
  output rd_result_t         res
);
  logic sgn, top;

  assign sgn = word[RES_W];
  assign top = word[RES_W-1];

  always_comb begin
    res = '0;
    if (tout) begin
      res.tout = 1'b1;
    end else begin
      res.data  = word[RES_W-1:0];
      res.sign  = sgn;
      res.over  = sgn & top;
      res.under = ~sgn & ~top;
      res.ferr  = word[RES_W+1];
    end
  end
endmodule

// File: rtl/adcr_gap.sv
module adcr_gap #(
  parameter int GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn,
  output logic done
);
  localparam int GW = $clog2(GAP + 1) + 1;
  localparam logic [GW-1:0] LIM = GW'(GAP);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= LIM;
    else if (!csn)       cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q >= LIM);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adcr_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int GAP    = 8,
  parameter int TW     = 16,
  parameter bit IRQ_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid_i,
  output logic          start_ready_o,
  input  logic [TW-1:0] cfg_timeout_i,
  input  logic          sdo_i,
  output logic          csn_o,
  output logic          sclk_o,
  output logic          eoc_irq_o,
  output logic          res_valid_o,
  input  logic          res_ready_i,
  output logic [20:0]   res_data_o,
  output logic          res_sign_o,
  output logic          res_over_o,
  output logic          res_under_o,
  output logic          res_ferr_o,
  output logic          res_tout_o
);
  rd_state_e          state_q;
  logic               sclk_q;
  logic [TW-1:0]      poll_q;
  logic               tout_q;
  logic               tick, gap_done, cap, clr, tick_en;
  logic [FRAME_W-1:0] word;
  logic [CNT_W-1:0]   bit_cnt;
  rd_result_t         dec, res_q;
  logic               res_valid_q;
  logic [TW:0]        lim, next_poll;

  assign tick_en = (state_q == ST_SEL) || (state_q == ST_POLL) || (state_q == ST_SHIFT);
  assign cap     = (state_q == ST_SHIFT) && tick && !sclk_q;
  assign clr     = (state_q == ST_IDLE) && start_valid_i && start_ready_o;
  assign lim       = (cfg_timeout_i == '0) ? (TW+1)'(1) : {1'b0, cfg_timeout_i};
  assign next_poll = {1'b0, poll_q} + 1'b1;

  adcr_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .tick(tick)
  );

  adcr_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cap(cap), .din(sdo_i),
    .word(word), .cnt(bit_cnt)
  );

  adcr_decode u_dec (
    .word(word), .tout(tout_q), .res(dec)
  );

  adcr_gap #(.GAP(GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .csn(csn_o), .done(gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      poll_q  <= '0;
      tout_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (clr) begin
          state_q <= ST_SEL;
          tout_q  <= 1'b0;
        end
        ST_SEL: if (tick) begin
          state_q <= ST_POLL;
          poll_q  <= '0;
        end
        ST_POLL: if (tick) begin
          if (!sdo_i) begin
            state_q <= ST_SHIFT;
          end else if (next_poll >= lim) begin
            state_q <= ST_DONE;
            tout_q  <= 1'b1;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        ST_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (bit_cnt == CNT_W'(FRAME_W)) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_q       <= '0;
    end else if (state_q == ST_DONE) begin
      res_valid_q <= 1'b1;
      res_q       <= dec;
    end else if (res_valid_q && res_ready_i) begin
      res_valid_q <= 1'b0;
    end
  end

  generate
    if (IRQ_EN) begin : g_irq
      assign eoc_irq_o = (state_q == ST_POLL) && !sdo_i;
    end else begin : g_no_irq
      assign eoc_irq_o = 1'b0;
    end
  endgenerate

  assign csn_o         = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign sclk_o        = sclk_q;
  assign start_ready_o = (state_q == ST_IDLE) && gap_done && !res_valid_q;
  assign res_valid_o   = res_valid_q;
  assign res_data_o    = res_q.data;
  assign res_sign_o    = res_q.sign;
  assign res_over_o    = res_q.over;
  assign res_under_o   = res_q.under;
  assign res_ferr_o    = res_q.ferr;
  assign res_tout_o    = res_q.tout;

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_o |-> !sclk_o);

  // R2
  sclk_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> !csn_o);

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)
      && $stable(res_sign_o) && $stable(res_ferr_o) && $stable(res_tout_o)));

  // R8
  tout_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_tout_o) |-> (res_data_o == '0 && !res_sign_o && !res_ferr_o));

  // R10
  gap_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn_o) |-> $past(gap_done));

  // R6
  range_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> !(res_over_o && res_under_o));
endmodule

// File: tb/test_adc_frame_reader.sv
`timescale 1ns/1ps
module test_adc_frame_reader;
  localparam int DIV = 4;
  localparam int GAP = 8;
  localparam int TW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [TW-1:0] cfg_timeout = 16'd40;
  logic          sdo;
  logic          csn, sclk, irq;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [20:0]   res_data;
  logic          res_sign, res_over, res_under, res_ferr, res_tout;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  adc_frame_reader #(.DIV(DIV), .GAP(GAP), .TW(TW), .IRQ_EN(1'b1)) i_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .start_valid_i(start_valid), .start_ready_o(start_ready),
    .cfg_timeout_i(cfg_timeout), .sdo_i(sdo), .csn_o(csn), .sclk_o(sclk),
    .eoc_irq_o(irq), .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_data_o(res_data), .res_sign_o(res_sign), .res_over_o(res_over),
    .res_under_o(res_under), .res_ferr_o(res_ferr), .res_tout_o(res_tout)
  );

  // converter model: busy for s_delay clocks after select falls, then frame bits
  logic [23:0] s_frame = '0;
  int          s_delay = 0;
  int          s_idx = 23;
  int          s_cnt = 0;
  logic        s_prev = 1'b0;

  always @(negedge clk) begin
    if (csn) begin
      s_idx = 23;
      s_cnt = 0;
      sdo <= 1'b1;
    end else begin
      if (s_prev && !sclk) s_idx = s_idx - 1;
      if (s_cnt < s_delay) begin
        s_cnt = s_cnt + 1;
        sdo <= 1'b1;
      end else begin
        sdo <= (s_idx >= 0) ? s_frame[s_idx] : 1'b1;
      end
    end
    s_prev = sclk;
  end

  // line monitor
  int   rises = 0, phase_bad = 0, irq_rises = 0, gap_bad = 0;
  int   run = 0, hi_run = 0;
  logic m_sclk = 1'b0, m_irq = 1'b0, m_csn = 1'b1, seen_read = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk != m_sclk) begin
        if (m_sclk || rises > 0) begin
          if (run != DIV) phase_bad = phase_bad + 1;
        end
        if (sclk) rises = rises + 1;
        run = 1;
      end else begin
        run = run + 1;
      end
      if (sclk && csn) phase_bad = phase_bad + 1;
      if (irq && !m_irq) irq_rises = irq_rises + 1;
      if (csn) hi_run = hi_run + 1;
      if (!csn && m_csn) begin
        if (seen_read && hi_run < GAP) gap_bad = gap_bad + 1;
        seen_read = 1'b1;
        hi_run = 0;
        run = 0;
      end
      m_sclk = sclk; m_irq = irq; m_csn = csn;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue_start();
    int n = 0;
    @(negedge clk);
    while (!start_ready && n < 5000) begin @(negedge clk); n++; end
    rises = 0; irq_rises = 0; phase_bad = 0;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic wait_valid(output bit ok);
    int n = 0;
    ok = 1'b0;
    while (!res_valid && n < 20000) begin @(negedge clk); n++; end
    ok = res_valid;
  endtask

  task automatic take_result();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  // one complete read, all fields checked against the word
  task automatic read_frame(input string name, input bit dmy, input bit sgn,
                            input bit msb, input logic [19:0] low, input int delay);
    bit ok;
    logic [20:0] exp_data;
    s_frame = {1'b0, dmy, sgn, msb, low};
    s_delay = delay;
    exp_data = {msb, low};
    issue_start();
    wait_valid(ok);
    chk("R4", {name, " result arrives"}, ok, 1);
    chk("R5", {name, " data"}, res_data, exp_data);
    chk("R5", {name, " sign"}, res_sign, sgn);
    chk("R6", {name, " over"}, res_over, sgn & msb);
    chk("R6", {name, " under"}, res_under, !sgn & !msb);
    chk("R7", {name, " ferr"}, res_ferr, dmy);
    chk("R8", {name, " no timeout"}, res_tout, 0);
    chk("R4", {name, " rising edges"}, rises, 24);
    chk("R2", {name, " phase widths"}, phase_bad, 0);
    chk("R3", {name, " irq pulses"}, irq_rises, 1);
    chk("R9", {name, " select high at result"}, csn, 1);
    take_result();
  endtask

  task automatic t_reset();
    chk("R1", "select", csn, 1);
    chk("R1", "sclk", sclk, 0);
    chk("R1", "valid", res_valid, 0);
    chk("R1", "start_ready", start_ready, 1);
  endtask

  task automatic t_ranges();
    read_frame("pos", 1'b0, 1'b1, 1'b0, 20'hAAAAA, 3);
    read_frame("neg", 1'b0, 1'b0, 1'b1, 20'h55555, 17);
    read_frame("over", 1'b0, 1'b1, 1'b1, 20'h00000, 0);
    read_frame("under", 1'b0, 1'b0, 1'b0, 20'hFFFFF, 40);
    read_frame("single", 1'b0, 1'b1, 1'b0, 20'h00001, 5);
  endtask

  task automatic t_ferr();
    read_frame("dummy_hi", 1'b1, 1'b1, 1'b0, 20'h80000, 9);
  endtask

  task automatic t_wait_sclk();
    // R3: no clock while the converter is busy
    int n;
    s_frame = 24'h2ABCDE;
    s_delay = 60;
    issue_start();
    for (n = 0; n < 50; n++) @(negedge clk);
    chk("R3", "no sclk while busy", rises, 0);
    chk("R3", "no irq while busy", irq_rises, 0);
    begin bit ok; wait_valid(ok); chk("R3", "read after busy", ok, 1); end
    chk("R4", "edges after busy", rises, 24);
    take_result();
  endtask

  task automatic t_backpressure();
    logic [20:0] held;
    bit ok;
    s_frame = {3'b001, 21'h13579};
    s_delay = 2;
    issue_start();
    wait_valid(ok);
    held = res_data;
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk("R9", "valid held", res_valid, 1);
    chk("R9", "data held", res_data, held);
    chk("R9", "no start while pending", start_ready, 0);
    take_result();
    chk("R9", "valid drops after ready", res_valid, 0);
  endtask

  task automatic t_timeout();
    bit ok;
    cfg_timeout = 16'd6;
    s_frame = 24'h0FFFFF;
    s_delay = 100000;
    issue_start();
    wait_valid(ok);
    chk("R8", "result arrives", ok, 1);
    chk("R8", "tout flag", res_tout, 1);
    chk("R8", "data zero", res_data, 0);
    chk("R8", "flags zero", {res_sign, res_over, res_under, res_ferr}, 0);
    chk("R8", "no sclk", rises, 0);
    chk("R8", "select high", csn, 1);
    take_result();
    cfg_timeout = 16'd40;
    s_delay = 0;
  endtask

  task automatic t_gap();
    read_frame("b2b_a", 1'b0, 1'b1, 1'b0, 20'h12345, 0);
    read_frame("b2b_b", 1'b0, 1'b0, 1'b1, 20'h6789A, 0);
    chk("R10", "select high time", gap_bad, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ranges();
    t_ferr();
    t_wait_sclk();
    t_backpressure();
    t_timeout();
    t_gap();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule